// File: doc/BRIEF.md
# Test-Access-Port Instruction and Data-Register Path

This block is the instruction-dependent half of a boundary-scan test port on a memory device. A separate 16-state controller drives one-cycle state strobes: test-logic-reset, plus capture, shift and update for both the instruction and data paths. From those strobes the block keeps an 8-bit instruction register and decodes the active opcode. It chooses which data register sits between `tdi` and `tdo`: a one-bit bypass cell, a 32-bit identification register, or a boundary register whose length is a parameter. It also decides whether the device pads carry functional data, carry held boundary data, or float.

The boundary register has a shift stage and a separate update stage, so pad values only change in Update-DR. `tdo` is re-timed on the falling edge of `tck`, while every other register samples on the rising edge. Any opcode outside the defined set behaves as bypass and leaves the pads in functional mode.

Top module: `tap_insn_datapath`

## Requirements
- R1: In Capture-IR the instruction shift stage loads 8'b0000_0001. In Shift-IR it shifts one bit per cycle, with `tdi` entering the MSB and the LSB presented on `tdo`.
- R2: A shifted opcode becomes active only in a cycle with `st_upd_ir`. Before that cycle the previously active instruction keeps control of the data path and the pads.
- R3: After `trst_n` is asserted, and after any cycle with `st_tlr`, the active instruction is IDCODE (default code 8'h21).
- R4: Under IDCODE, Capture-DR loads the identification value (default 32'h2B6D104F). Shift-DR then emits its 32 bits LSB first, followed by the bits entered on `tdi`.
- R5: BYPASS (8'hFF) and every opcode outside the defined set select the one-bit bypass cell, which captures 0. The pads follow `core_out` and `core_oe`.
- R6: SAMPLE/PRELOAD (default 8'h05) captures `pad_obs` into the boundary shift stage in Capture-DR. It shifts that stage in Shift-DR, with bit 0 nearest `tdo`, and loads the update stage in Update-DR. The pads stay functional.
- R7: EXTEST (default 8'h00) selects the boundary register and captures `pad_obs` in the same way as R6. Once it is active, it drives `pad_out` from update-stage bits [N_OUT-1:0] with `pad_oe` high.
- R8: CLAMP (default 8'h07) drives `pad_out` from update-stage bits [N_OUT-1:0] with `pad_oe` high, and selects the bypass cell as the scan path.
- R9: HIGH-Z (default 8'h03) holds `pad_oe` low and selects the bypass cell as the scan path.
- R10: The boundary update stage changes only in an Update-DR cycle while a boundary instruction is active. Pad values therefore stay constant throughout Shift-DR.
- R11: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is high only for a shift state, and `tdo` is 0 outside shift states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| st_tlr | input | 1 | Controller is in test-logic-reset |
| st_cap_ir | input | 1 | Controller is in Capture-IR |
| st_shift_ir | input | 1 | Controller is in Shift-IR |
| st_upd_ir | input | 1 | Controller is in Update-IR |
| st_cap_dr | input | 1 | Controller is in Capture-DR |
| st_shift_dr | input | 1 | Controller is in Shift-DR |
| st_upd_dr | input | 1 | Controller is in Update-DR |
| tdi | input | 1 | Serial test data in |
| pad_obs | input | BS_LEN | Observed pad values for boundary capture |
| core_out | input | N_OUT | Functional output data from the core |
| core_oe | input | 1 | Functional output enable from the core |
| pad_out | output | N_OUT | Data sent to the output pads |
| pad_oe | output | 1 | Output-driver enable for the pads |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Enable for the `tdo` driver |

## Verification
The assertions check several rules on every clock edge:
- the active opcode holds between updates, and a test-logic-reset cycle forces IDCODE;
- the instruction stage loads its fixed capture pattern;
- the bypass cell captures zero;
- the boundary update stage holds outside boundary Update-DR cycles;
- `tdo` stays quiet when no shift state is present;
- the high-impedance mode never routes through a long register.

Only the bench scenarios can show the serial behaviour end to end. These are the exact bit streams returned for each opcode, the drive of preloaded values by EXTEST and CLAMP, the fall-back of reserved codes to bypass, and recovery after an asynchronous reset.

// File: rtl/tap_path_pkg.sv
package tap_path_pkg;

  // Scan path placed between tdi and tdo
  typedef enum logic [1:0] {
    DR_BYPASS = 2'd0,
    DR_IDENT  = 2'd1,
    DR_BOUND  = 2'd2
  } dr_sel_e;

  // Source of the pad drive
  typedef enum logic [1:0] {
    PAD_FUNC = 2'd0,
    PAD_HOLD = 2'd1,
    PAD_OFF  = 2'd2
  } pad_mode_e;

  typedef struct packed {
    dr_sel_e   dr_sel;
    pad_mode_e pad_mode;
  } insn_ctl_t;

endpackage

// File: rtl/tap_ir_stage.sv
module tap_ir_stage #(
  parameter int                IR_W     = 8,
  parameter logic [IR_W-1:0]   RESET_OP = '0,
  parameter logic [IR_W-1:0]   CAP_VAL  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tlr,
  input  logic            cap,
  input  logic            shift,
  input  logic            upd,
  input  logic            tdi,
  output logic            sh_lsb,
  output logic [IR_W-1:0] active
);

  logic [IR_W-1:0] sh_q, sh_d;
  logic [IR_W-1:0] act_q, act_d;
  logic            sh_en, act_en;

  assign sh_en  = cap | shift;
  assign act_en = tlr | upd;

  always_comb begin
    sh_d  = sh_q;
    act_d = act_q;
    if (cap) begin
      sh_d = CAP_VAL;
    end else if (shift) begin
      sh_d = {tdi, sh_q[IR_W-1:1]};
    end
    if (tlr) begin
      act_d = RESET_OP;
    end else if (upd) begin
      act_d = sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= CAP_VAL;
      act_q <= RESET_OP;
    end else begin
      if (sh_en)  sh_q  <= sh_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign sh_lsb = sh_q[0];
  assign active = act_q;

  assert_ir_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (sh_q == CAP_VAL));

  assert_ir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !tlr) |=> $stable(act_q));

  assert_ir_tlr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tlr |=> (act_q == RESET_OP));

endmodule

// File: rtl/tap_insn_decode.sv
module tap_insn_decode
  import tap_path_pkg::*;
#(
  parameter int              IR_W      = 8,
  parameter logic [IR_W-1:0] OP_EXTEST = '0,
  parameter logic [IR_W-1:0] OP_IDCODE = '0,
  parameter logic [IR_W-1:0] OP_SAMPLE = '0,
  parameter logic [IR_W-1:0] OP_CLAMP  = '0,
  parameter logic [IR_W-1:0] OP_HIGHZ  = '0
) (
  input  logic [IR_W-1:0] opcode,
  output insn_ctl_t       ctl
);

  always_comb begin
    ctl.dr_sel   = DR_BYPASS;
    ctl.pad_mode = PAD_FUNC;
    if (opcode == OP_EXTEST) begin
      ctl.dr_sel   = DR_BOUND;
      ctl.pad_mode = PAD_HOLD;
    end else if (opcode == OP_IDCODE) begin
      ctl.dr_sel   = DR_IDENT;
    end else if (opcode == OP_SAMPLE) begin
      ctl.dr_sel   = DR_BOUND;
    end else if (opcode == OP_CLAMP) begin
      ctl.pad_mode = PAD_HOLD;
    end else if (opcode == OP_HIGHZ) begin
      ctl.pad_mode = PAD_OFF;
    end
    // all-ones and reserved codes keep the bypass / functional default
  end

  always_comb begin
    if (ctl.pad_mode == PAD_OFF) begin
      assert_off_uses_bypass_R9: assert (ctl.dr_sel == DR_BYPASS);
    end
  end

endmodule

// File: rtl/tap_shreg.sv
module tap_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r, q_d, shin;
  logic         en;

  generate
    if (W == 1) begin : g_one
      assign shin = tdi;
    end else begin : g_many
      assign shin = {tdi, q_r[W-1:1]};
    end
  endgenerate

  assign en = cap | shift;

  always_comb begin
    q_d = q_r;
    if (cap)        q_d = cap_val;
    else if (shift) q_d = shin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_d;
  end

  assign q = q_r;

endmodule

// File: rtl/tap_insn_datapath.sv
module tap_insn_datapath
  import tap_path_pkg::*;
#(
  parameter int          IR_W      = 8,
  parameter int          BS_LEN    = 12,
  parameter int          N_OUT     = 4,
  parameter logic [31:0] ID_VALUE  = 32'h2B6D_104F,
  parameter logic [IR_W-1:0] OP_EXTEST = 8'h00,
  parameter logic [IR_W-1:0] OP_IDCODE = 8'h21,
  parameter logic [IR_W-1:0] OP_SAMPLE = 8'h05,
  parameter logic [IR_W-1:0] OP_CLAMP  = 8'h07,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 8'h03
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              st_tlr,
  input  logic              st_cap_ir,
  input  logic              st_shift_ir,
  input  logic              st_upd_ir,
  input  logic              st_cap_dr,
  input  logic              st_shift_dr,
  input  logic              st_upd_dr,
  input  logic              tdi,
  input  logic [BS_LEN-1:0] pad_obs,
  input  logic [N_OUT-1:0]  core_out,
  input  logic              core_oe,
  output logic [N_OUT-1:0]  pad_out,
  output logic              pad_oe,
  output logic              tdo,
  output logic              tdo_en
);

  localparam int              ID_W   = 32;
  localparam logic [IR_W-1:0] IR_CAP = {{(IR_W-1){1'b0}}, 1'b1};

  // reset: asserted asynchronously, released on the second tck edge
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // instruction register and decode
  logic            ir_lsb;
  logic [IR_W-1:0] ir_active;
  insn_ctl_t       ctl;

  tap_ir_stage #(
    .IR_W     (IR_W),
    .RESET_OP (OP_IDCODE),
    .CAP_VAL  (IR_CAP)
  ) u_ir (
    .clk    (tck),
    .rst_n  (rst_n),
    .tlr    (st_tlr),
    .cap    (st_cap_ir),
    .shift  (st_shift_ir),
    .upd    (st_upd_ir),
    .tdi    (tdi),
    .sh_lsb (ir_lsb),
    .active (ir_active)
  );

  tap_insn_decode #(
    .IR_W      (IR_W),
    .OP_EXTEST (OP_EXTEST),
    .OP_IDCODE (OP_IDCODE),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_CLAMP  (OP_CLAMP),
    .OP_HIGHZ  (OP_HIGHZ)
  ) u_dec (
    .opcode (ir_active),
    .ctl    (ctl)
  );

  // data registers
  logic sel_byp, sel_id, sel_bs;
  assign sel_byp = (ctl.dr_sel == DR_BYPASS);
  assign sel_id  = (ctl.dr_sel == DR_IDENT);
  assign sel_bs  = (ctl.dr_sel == DR_BOUND);

  logic [0:0]        byp_q;
  logic [ID_W-1:0]   id_q;
  logic [BS_LEN-1:0] bs_sh_q;

  tap_shreg #(.W(1)) u_byp (
    .clk     (tck),
    .rst_n   (rst_n),
    .cap     (st_cap_dr & sel_byp),
    .shift   (st_shift_dr & sel_byp),
    .tdi     (tdi),
    .cap_val (1'b0),
    .q       (byp_q)
  );

  tap_shreg #(.W(ID_W)) u_id (
    .clk     (tck),
    .rst_n   (rst_n),
    .cap     (st_cap_dr & sel_id),
    .shift   (st_shift_dr & sel_id),
    .tdi     (tdi),
    .cap_val (ID_VALUE),
    .q       (id_q)
  );

  tap_shreg #(.W(BS_LEN)) u_bs (
    .clk     (tck),
    .rst_n   (rst_n),
    .cap     (st_cap_dr & sel_bs),
    .shift   (st_shift_dr & sel_bs),
    .tdi     (tdi),
    .cap_val (pad_obs),
    .q       (bs_sh_q)
  );

  // boundary update stage
  logic [BS_LEN-1:0] bs_upd_q;
  logic              bs_upd_en;

  assign bs_upd_en = st_upd_dr & sel_bs;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)         bs_upd_q <= '0;
    else if (bs_upd_en) bs_upd_q <= bs_sh_q;
  end

  // pad control
  always_comb begin
    pad_out = core_out;
    pad_oe  = core_oe;
    case (ctl.pad_mode)
      PAD_HOLD: begin
        pad_out = bs_upd_q[N_OUT-1:0];
        pad_oe  = 1'b1;
      end
      PAD_OFF:  pad_oe = 1'b0;
      default:  ;
    endcase
  end

  // tdo re-timed on the falling edge
  logic tdo_d, tdo_en_d;

  always_comb begin
    tdo_d = 1'b0;
    if (st_shift_ir) begin
      tdo_d = ir_lsb;
    end else if (st_shift_dr) begin
      case (ctl.dr_sel)
        DR_IDENT: tdo_d = id_q[0];
        DR_BOUND: tdo_d = bs_sh_q[0];
        default:  tdo_d = byp_q[0];
      endcase
    end
    tdo_en_d = st_shift_ir | st_shift_dr;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= tdo_en_d;
    end
  end

  assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (st_cap_dr && sel_byp) |=> (byp_q == 1'b0));

  assert_bs_update_hold_R10: assert property (@(posedge tck) disable iff (!rst_n)
    !bs_upd_en |=> $stable(bs_upd_q));

  assert_tdo_idle_R11: assert property (@(negedge tck) disable iff (!rst_n)
    (!st_shift_ir && !st_shift_dr) |=> (!tdo_en && !tdo));

endmodule

// File: tb/tap_insn_datapath_tb.sv
module tap_insn_datapath_tb;

  localparam int          BS = 12;
  localparam int          NO = 4;
  localparam logic [31:0] IDV = 32'h2B6D_104F;
  localparam logic [7:0]  C_EXT = 8'h00, C_ID = 8'h21, C_SMP = 8'h05,
                          C_CLP = 8'h07, C_HZ = 8'h03, C_BYP = 8'hFF;

  // vector: opcode[11:4], path[3:2] (0 bypass,1 id,2 boundary), pad[1:0] (0 func,1 hold,2 off)
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {C_BYP, 2'd0, 2'd0},
    {C_ID,  2'd1, 2'd0},
    {C_SMP, 2'd2, 2'd0},
    {C_EXT, 2'd2, 2'd1},
    {C_CLP, 2'd0, 2'd1},
    {C_HZ,  2'd0, 2'd2},
    {8'h5A, 2'd0, 2'd0},
    {8'h10, 2'd0, 2'd0}
  };

  logic tck = 1'b0;
  logic trst_n, st_tlr, st_cap_ir, st_shift_ir, st_upd_ir;
  logic st_cap_dr, st_shift_dr, st_upd_dr, tdi;
  logic [BS-1:0] pad_obs;
  logic [NO-1:0] core_out, pad_out;
  logic core_oe, pad_oe, tdo, tdo_en;

  int n_chk = 0;
  int n_bad = 0;
  logic [BS-1:0] model_upd;

  always #5 tck = ~tck;

  tap_insn_datapath u_dut (
    .tck(tck), .trst_n(trst_n), .st_tlr(st_tlr), .st_cap_ir(st_cap_ir),
    .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr),
    .st_shift_dr(st_shift_dr), .st_upd_dr(st_upd_dr), .tdi(tdi),
    .pad_obs(pad_obs), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .tdo(tdo), .tdo_en(tdo_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck); #1;
  endtask

  task automatic ir_shift(input logic [7:0] op, output logic [7:0] got);
    st_cap_ir = 1'b1; tick(); st_cap_ir = 1'b0;
    for (int i = 0; i < 8; i++) begin
      st_shift_ir = 1'b1; tdi = op[i];
      @(negedge tck); #1; got[i] = tdo;
      tick();
    end
    st_shift_ir = 1'b0;
  endtask

  task automatic ir_update();
    st_upd_ir = 1'b1; tick(); st_upd_ir = 1'b0;
  endtask

  task automatic load_ir(input logic [7:0] op, output logic [7:0] got);
    ir_shift(op, got);
    ir_update();
  endtask

  task automatic dr_scan(input logic [39:0] din, output logic [39:0] dout,
                         output bit moved, output bit en_bad);
    logic [NO-1:0] p0;
    st_cap_dr = 1'b1; tick(); st_cap_dr = 1'b0;
    p0 = pad_out; moved = 0; en_bad = 0;
    for (int i = 0; i < 40; i++) begin
      st_shift_dr = 1'b1; tdi = din[i];
      @(negedge tck); #1; dout[i] = tdo;
      if (pad_out !== p0) moved = 1;
      if (tdo_en !== 1'b1) en_bad = 1;
      tick();
    end
    st_shift_dr = 1'b0;
    st_upd_dr = 1'b1; tick(); st_upd_dr = 1'b0;
  endtask

  function automatic logic [39:0] exp_scan(input logic [1:0] path, input logic [39:0] din,
                                           input logic [BS-1:0] q);
    case (path)
      2'd1:    return {din[7:0], IDV};
      2'd2:    return {din[27:0], q};
      default: return {din[38:0], 1'b0};
    endcase
  endfunction

  task automatic chk_pads(input logic [1:0] mode, input string req);
    case (mode)
      2'd1: chk(pad_oe === 1'b1 && pad_out === model_upd[NO-1:0], req, "pads held",
                {pad_oe, pad_out}, {1'b1, model_upd[NO-1:0]});
      2'd2: chk(pad_oe === 1'b0, req, "pads off", pad_oe, 1'b0);
      default: chk(pad_oe === core_oe && pad_out === core_out, req, "pads functional",
                   {pad_oe, pad_out}, {core_oe, core_out});
    endcase
  endtask

  function automatic string tag_of(input logic [1:0] path, input logic [1:0] pad);
    if (path == 2'd1) return "R4";
    if (path == 2'd2) return (pad == 2'd1) ? "R7" : "R6";
    if (pad == 2'd1)  return "R8";
    if (pad == 2'd2)  return "R9";
    return "R5";
  endfunction

  task automatic do_reset();
    trst_n = 1'b0;
    repeat (3) tick();
    trst_n = 1'b1;
    repeat (3) tick();
    model_upd = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  irc;
    logic [39:0] din, dout;
    bit          moved, en_bad;
    string       tg;

    st_tlr = 0; st_cap_ir = 0; st_shift_ir = 0; st_upd_ir = 0;
    st_cap_dr = 0; st_shift_dr = 0; st_upd_dr = 0; tdi = 0;
    pad_obs = 12'h5C3; core_out = 4'h9; core_oe = 1'b1;
    do_reset();

    // reset state: R3 and R11
    chk(tdo_en === 1'b0 && tdo === 1'b0, "R11", "idle tdo after reset", {tdo_en, tdo}, 2'b00);
    chk_pads(2'd0, "R3");
    din = 40'hA1_0000_0000;
    dr_scan(din, dout, moved, en_bad);
    chk(dout === exp_scan(2'd1, din, pad_obs), "R3", "IDCODE after reset", dout, exp_scan(2'd1, din, pad_obs));

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [7:0] op;
      logic [1:0] path, pad;
      op = VEC[v][11:4]; path = VEC[v][3:2]; pad = VEC[v][1:0];
      tg = tag_of(path, pad);
      pad_obs  = 12'h5C3 + 12'(v * 37);
      core_out = 4'(v + 3);
      core_oe  = v[0];
      load_ir(op, irc);
      chk(irc === 8'h01, "R1", "IR capture pattern", irc, 8'h01);
      chk_pads(pad, tg);
      din = {8'hC5 ^ 8'(v), 32'h9E37_79B9 ^ 32'(v * 32'h0101_0101)};
      dr_scan(din, dout, moved, en_bad);
      chk(dout === exp_scan(path, din, pad_obs), tg, "scan stream", dout, exp_scan(path, din, pad_obs));
      chk(!moved, "R10", "pads stable in shift", moved, 0);
      chk(!en_bad, "R11", "tdo_en during shift", en_bad, 0);
      if (path == 2'd2) model_upd = din[39:28];
      chk_pads(pad, tg);
      chk(tdo_en === 1'b0 && tdo === 1'b0, "R11", "tdo idle after scan", {tdo_en, tdo}, 2'b00);
    end

    // R2: shifted-in opcode waits for update
    core_out = 4'h6; core_oe = 1'b1;
    load_ir(C_EXT, irc);
    ir_shift(C_BYP, irc);
    chk_pads(2'd1, "R2");
    tick();
    chk_pads(2'd1, "R2");
    ir_update();
    chk_pads(2'd0, "R2");

    // R3: test-logic-reset strobe returns to IDCODE
    load_ir(C_EXT, irc);
    chk_pads(2'd1, "R3");
    st_tlr = 1'b1; tick(); st_tlr = 1'b0;
    chk_pads(2'd0, "R3");
    din = 40'h3C_0000_0000;
    dr_scan(din, dout, moved, en_bad);
    chk(dout === exp_scan(2'd1, din, pad_obs), "R3", "IDCODE after tlr", dout, exp_scan(2'd1, din, pad_obs));

    // R10: CLAMP scan leaves the update stage alone
    load_ir(C_CLP, irc);
    din = 40'hFF_FFFF_FFFF;
    dr_scan(din, dout, moved, en_bad);
    chk_pads(2'd1, "R10");

    // R3: asynchronous reset clears instruction and update stage
    load_ir(C_EXT, irc);
    #2 trst_n = 1'b0;
    #1;
    chk_pads(2'd0, "R3");
    @(posedge tck); #1;
    trst_n = 1'b1;
    repeat (3) tick();
    model_upd = '0;
    load_ir(C_EXT, irc);
    chk_pads(2'd1, "R3");

    summary();
    $finish;
  end

endmodule